// File: doc/BRIEF.md
# Decoupled Pipelined Loop Accumulator

This block computes the sum of a counted loop, 0 + 1 + ... + (TRIP-1), in hardware. It is built from two independent handshaking loops instead of one lock-step counter and adder. An index generator produces the values i = 0, 1, 2, ... together with a continue/stop predicate (i < TRIP). The predicate goes into a small FIFO. Each index that the predicate allows goes into a multi-stage elastic pipeline. An accumulation loop takes the predicates in order. For a true predicate it waits for the matching value at the pipeline output and adds it to the running sum. For a false predicate it stops and presents the result.

The FIFO lets the index generator run ahead of the accumulator, so several values can be in flight in the pipeline at once. With a one-entry FIFO the two loops nearly alternate. With a FIFO deeper than the pipeline, the loop retires one iteration per cycle.

A single-cycle `start` pulse begins a run. `busy` is high while the run is in progress. `done` goes high, with `result` valid, when the run finishes, and both hold until the next accepted start.

Top module: `loop_sum_engine`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `result` is 0.
- R2: A `start` pulse seen while `busy` is 0 makes `busy` 1 and `done` 0 from the next cycle. `busy` and `done` are never both high.
- R3: When `done` rises, `result` equals TRIP*(TRIP-1)/2, which is 4950 for the default TRIP of 100. This holds for every predicate FIFO depth of at least 1 and every pipeline stage count of at least 1.
- R4: With TRIP = 0 the first predicate is false. The run still finishes, with `done` = 1 and `result` = 0.
- R5: Once `done` is 1, `done` stays 1 and `result` stays unchanged until the next accepted `start`.
- R6: A `start` pulse while `busy` is 1 is ignored. Both the result and the completion time of the run in progress are unaffected.
- R7: The completion time, counted in cycles from start to `done`, does not grow as the predicate FIFO gets deeper. With 8 pipeline stages, depth 2 finishes strictly sooner than depth 1. With a FIFO deeper than the pipeline, a run takes at most TRIP + STAGES + 8 cycles.
- R8: The predicate FIFO is never written while full and never read while empty.
- R9: The accumulator adds a value only in a cycle where the head predicate is true and the pipeline output is valid. A false head predicate ends the run.
- R10: The index generator never emits an index above TRIP. The index TRIP itself is emitted only with a false predicate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run complete; `result` is valid |
| result | output | 32 | Final accumulated sum |

## Verification
The bench runs seven configurations side by side. Five of them share TRIP = 100 and 8 pipeline stages and differ only in FIFO depth (1, 2, 4, 8, 16). Comparing these isolates the effect of run-ahead on completion time, while the sum must stay at 4950. A TRIP = 0 configuration checks the immediate-stop path. A one-stage pipeline with TRIP = 7 checks the sum when there is almost no latency to hide. Runs are repeated back to back, and one run receives a stray start pulse mid-way; that run's cycle count must match the earlier clean run exactly, and its result must be unchanged.

// File: rtl/loop_sum_pkg.sv
package loop_sum_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // Advance the induction variable by one step.
  function automatic word_t next_index(input word_t idx);
    return idx + word_t'(1);
  endfunction

  // Loop-control predicate: keep iterating while the index is below the trip count.
  function automatic logic keep_going(input word_t idx, input int unsigned trip);
    return (idx < word_t'(trip));
  endfunction

  // One accumulation step.
  function automatic word_t accumulate(input word_t sum, input word_t term);
    return sum + term;
  endfunction
endpackage

// File: rtl/loop_sum_index_gen.sv
module loop_sum_index_gen
  import loop_sum_pkg::*;
#(
  parameter int unsigned TRIP = 100
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  launch,
  input  logic  pred_room,
  input  logic  data_room,
  output logic  pred_push,
  output logic  pred_bit,
  output logic  data_push,
  output word_t data_val,
  output logic  emit,
  output word_t idx_now
);
  logic  active_q;
  word_t idx_q;

  assign idx_now   = idx_q;
  assign pred_bit  = keep_going(idx_q, TRIP);
  // A true predicate needs space in both the FIFO and the pipeline;
  // a false one only needs FIFO space.
  assign emit      = active_q && pred_room && (!pred_bit || data_room);
  assign pred_push = emit;
  assign data_push = emit && pred_bit;
  assign data_val  = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (launch) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (emit) begin
      if (pred_bit) idx_q    <= next_index(idx_q);
      else          active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/loop_sum_pred_fifo.sv
module loop_sum_pred_fifo #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic din,
  input  logic pop,
  output logic dout,
  output logic full,
  output logic empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = mem_q[rd_q];

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) begin
        mem_q[wr_q] <= din;
        wr_q        <= wrap_inc(wr_q);
      end
      if (pop) rd_q <= wrap_inc(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop && !push) cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/loop_sum_pipe.sv
module loop_sum_pipe
  import loop_sum_pkg::*;
#(
  parameter int unsigned STAGES = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  word_t in_data,
  output logic  out_valid,
  input  logic  out_ready,
  output word_t out_data
);
  logic  vld_q [STAGES];
  word_t dat_q [STAGES];
  logic  rdy   [STAGES+1];

  assign rdy[STAGES] = out_ready;
  assign in_ready    = rdy[0];
  assign out_valid   = vld_q[STAGES-1];
  assign out_data    = dat_q[STAGES-1];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic  up_v;
    word_t up_d;
    // A stage can load when it is empty or its content moves on this cycle.
    assign rdy[s] = !vld_q[s] || rdy[s+1];
    if (s == 0) begin : g_head
      assign up_v = in_valid;
      assign up_d = in_data;
    end else begin : g_body
      assign up_v = vld_q[s-1];
      assign up_d = dat_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
        dat_q[s] <= '0;
      end else if (rdy[s]) begin
        vld_q[s] <= up_v;
        if (up_v) dat_q[s] <= up_d;
      end
    end
  end
endmodule

// File: rtl/loop_sum_engine.sv
module loop_sum_engine
  import loop_sum_pkg::*;
#(
  parameter int unsigned TRIP       = 100,
  parameter int unsigned STAGES     = 8,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic [31:0] result
);
  logic  busy_q, done_q;
  word_t sum_q;

  logic  launch;
  logic  pred_push, pred_bit, pred_pop, pred_head, fifo_full, fifo_empty;
  logic  data_push, pipe_in_ready, pipe_out_valid, acc_take, acc_stop;
  word_t data_val, pipe_out_data, ind_idx;
  logic  ind_emit;

  assign launch = start && !busy_q;

  loop_sum_index_gen #(.TRIP(TRIP)) u_idx (
    .clk(clk), .rst_n(rst_n), .launch(launch),
    .pred_room(!fifo_full), .data_room(pipe_in_ready),
    .pred_push(pred_push), .pred_bit(pred_bit),
    .data_push(data_push), .data_val(data_val),
    .emit(ind_emit), .idx_now(ind_idx)
  );

  loop_sum_pred_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(pred_push), .din(pred_bit),
    .pop(pred_pop), .dout(pred_head), .full(fifo_full), .empty(fifo_empty)
  );

  loop_sum_pipe #(.STAGES(STAGES)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(data_push), .in_ready(pipe_in_ready), .in_data(data_val),
    .out_valid(pipe_out_valid), .out_ready(acc_take), .out_data(pipe_out_data)
  );

  // Accumulation loop: consume predicates in order.
  assign acc_take = busy_q && !fifo_empty && pred_head && pipe_out_valid;
  assign acc_stop = busy_q && !fifo_empty && !pred_head;
  assign pred_pop = acc_take || acc_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sum_q  <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      sum_q  <= '0;
    end else if (acc_take) begin
      sum_q <= accumulate(sum_q, pipe_out_data);
    end else if (acc_stop) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = sum_q;
endmodule

// File: rtl/loop_sum_checker.sv
module loop_sum_checker
  import loop_sum_pkg::*;
#(
  parameter int unsigned TRIP = 100
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] result,
  input logic        pred_push,
  input logic        pred_pop,
  input logic        pred_bit,
  input logic        fifo_full,
  input logic        fifo_empty,
  input logic        acc_take,
  input logic        pipe_out_valid,
  input logic        ind_emit,
  input word_t       ind_idx
);
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R2
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done)); // R2
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(pred_push && fifo_full && !pred_pop)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(pred_pop && fifo_empty)); // R8
  AST_ADD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    acc_take |-> (pipe_out_valid && busy)); // R9
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ind_emit |-> (ind_idx <= word_t'(TRIP))); // R10
  AST_LAST_IDX_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_emit && ind_idx == word_t'(TRIP)) |-> !pred_bit); // R10
endmodule

bind loop_sum_engine loop_sum_checker #(.TRIP(TRIP)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .pred_push(pred_push), .pred_pop(pred_pop),
  .pred_bit(pred_bit), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .acc_take(acc_take), .pipe_out_valid(pipe_out_valid),
  .ind_emit(ind_emit), .ind_idx(ind_idx)
);

// File: tb/loop_sum_engine_bench.sv
module loop_sum_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCFG = 7;
  localparam int DEPTHS [NCFG] = '{1, 2, 4, 8, 16, 3, 2};
  localparam int TRIPS  [NCFG] = '{100, 100, 100, 100, 100, 0, 7};
  localparam int STAGES [NCFG] = '{8, 8, 8, 8, 8, 8, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic        start_v  [NCFG];
  logic        busy_v   [NCFG];
  logic        done_v   [NCFG];
  logic [31:0] result_v [NCFG];
  int checks = 0;
  int fails = 0;
  int cyc_of [NCFG];
  int wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NCFG; g++) begin : g_dut
    if (g == 0) begin : g_main
      loop_sum_engine #(.TRIP(TRIPS[g]), .STAGES(STAGES[g]), .FIFO_DEPTH(DEPTHS[g])) u_loop_sum_engine (
        .clk(clk), .rst_n(rst_n), .start(start_v[g]),
        .busy(busy_v[g]), .done(done_v[g]), .result(result_v[g]));
    end else begin : g_alt
      loop_sum_engine #(.TRIP(TRIPS[g]), .STAGES(STAGES[g]), .FIFO_DEPTH(DEPTHS[g])) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start_v[g]),
        .busy(busy_v[g]), .done(done_v[g]), .result(result_v[g]));
    end
  end

  function automatic int expected_sum(input int trip);
    int s = 0;
    for (int i = 0; i < trip; i++) s += i;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Start a run on config k; optionally inject a stray start mid-run.
  task automatic run(input int k, input bit stray, output int cyc);
    @(negedge clk);
    start_v[k] = 1'b1;
    @(negedge clk);
    start_v[k] = 1'b0;
    cyc = 1;
    check(busy_v[k] == 1'b1 && done_v[k] == 1'b0, "R2 armed after start", busy_v[k], 1);
    while (!done_v[k] && cyc < 5000) begin
      start_v[k] = (stray && cyc == 20);
      @(negedge clk);
      cyc++;
    end
    start_v[k] = 1'b0;
    check(done_v[k] == 1'b1, "R3 run completes", done_v[k], 1);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < NCFG; k++) start_v[k] = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int k = 0; k < NCFG; k++) begin
      check(busy_v[k] == 0 && done_v[k] == 0, "R1 reset flags", {busy_v[k], done_v[k]}, 0);
      check(result_v[k] == 0, "R1 reset result", result_v[k], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R4 / R8 / R9 / R10: sum for every configuration
    for (int k = 0; k < NCFG; k++) begin
      int c;
      run(k, 1'b0, c);
      cyc_of[k] = c;
      check(result_v[k] == 32'(expected_sum(TRIPS[k])),
            (TRIPS[k] == 0) ? "R4 empty loop sum" : "R3 R9 R10 final sum",
            result_v[k], expected_sum(TRIPS[k]));
      // R5: done and result hold while idle
      repeat (6) @(negedge clk);
      check(done_v[k] == 1'b1 && busy_v[k] == 1'b0, "R5 done held", done_v[k], 1);
      check(result_v[k] == 32'(expected_sum(TRIPS[k])), "R5 result held",
            result_v[k], expected_sum(TRIPS[k]));
    end

    // R7: completion time versus FIFO depth (configs 0..4)
    check(cyc_of[1] < cyc_of[0], "R7 depth2 faster than depth1", cyc_of[1], cyc_of[0]);
    for (int k = 1; k < 4; k++)
      check(cyc_of[k+1] <= cyc_of[k], "R7 deeper not slower", cyc_of[k+1], cyc_of[k]);
    check(cyc_of[4] <= 100 + 8 + 8, "R7 deep FIFO near one per cycle", cyc_of[4], 116);

    // R6: stray start during a run changes nothing; also a clean restart
    for (int k = 0; k < 5; k++) begin
      int c;
      run(k, 1'b1, c);
      check(c == cyc_of[k], "R6 stray start timing", c, cyc_of[k]);
      check(result_v[k] == 32'd4950, "R6 stray start result", result_v[k], 4950);
    end

    // R2: restart after done clears done and sums again from zero
    begin
      int c;
      run(6, 1'b0, c);
      check(result_v[6] == 32'(expected_sum(TRIPS[6])), "R2 restart sum",
            result_v[6], expected_sum(TRIPS[6]));
      check(c == cyc_of[6], "R2 restart timing repeatable", c, cyc_of[6]);
    end

    finish_run();
  end
endmodule